// File: doc/BRIEF.md
# Pipelined Processor Bus Cycle Controller

This block runs the external bus cycles of a 32-bit processor core. The core offers one transfer at a time. A transfer carries a word address, a four-bit byte mask, a direction bit, a data/control class bit, a memory/IO class bit, a lock flag and write data. The controller strobes the address and the cycle definition for one clock, then waits in a data phase until the device signals ready. A read returns its data to the core with a one-clock pulse.

The controller also adapts to the device and to other bus masters. When a device reports that it is 16 bits wide, a transfer that uses the upper byte lanes is completed as a second cycle. When the device asks for the next address early, a waiting request is strobed while the current data phase is still open. When another master requests the bus, the controller lets go of it at a cycle boundary, unless a locked sequence is in progress.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset the strobe, lock and hold-acknowledge outputs are inactive (strobe and lock high, acknowledge low). The data bus is not driven, no response is pending, and the address and control outputs are enabled.
- R2: An accepted request is presented for exactly one clock with `ads_n` low, together with its address and its write, data/control and memory/IO definition. The data phase follows, so a cycle takes at least two clocks.
- R3: A data phase ends only at a clock edge where `rdy_n` is sampled low. Each clock with `rdy_n` high extends the cycle by one wait state.
- R4: `bus_be_n` is the bitwise inverse of the byte mask the core supplied for the cycle shown. It is 4'b1111 while no cycle is shown.
- R5: If `bs16_n` is low when a first-half data phase ends, and byte-mask bit 2 or bit 3 is set, a second cycle is strobed at the same address. In that second cycle `bus_be_n[1:0]` is 2'b11, `bus_be_n[3:2]` is the inverse of mask bits 3..2, and write data bits 31..16 are driven on data lines 15..0.
- R6: If no upper lane is set, a narrow-device transfer takes a single cycle. A read of that kind returns data lines 15..0 in bits 15..0 and zero in bits 31..16. A split read returns first-half lines 15..0 in bits 15..0 and second-half lines 15..0 in bits 31..16. A full-width read returns all 32 lines.
- R7: `rsp_valid` goes high for one clock, on the clock after the final ready of a read, and carries the merged data. Writes produce no pulse.
- R8: If `na_n` is low in a data-phase clock that does not end the cycle, and a request is waiting, that request is accepted. Its address, mask and definition are strobed on the next clock while the current data phase continues. Once the current transfer is done, the accepted request goes straight into its data phase with no new strobe. If a second half intervened, it is strobed again first.
- R9: A request accepted at the final ready of a cycle is strobed on the very next clock, with no idle clock in between. `req_ready` is high exactly in the clocks in which a request is taken.
- R10: When `hold` is high at a cycle boundary or in idle, and no lock is active, the controller raises `hlda` on the next clock. It then keeps `ads_n` high, keeps `bus_oe` and `d_oe` low, and stays released until the clock after `hold` is sampled low.
- R11: `lock_n` goes low when a request with its lock flag set is accepted. It stays low until a request without the flag is accepted. While `lock_n` is low, `hold` is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core offers a transfer |
| req_ready | output | 1 | Transfer taken this clock |
| req_addr | input | 30 | Word address of the transfer |
| req_be | input | 4 | Byte mask, active high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_dc | input | 1 | 1 = data, 0 = control |
| req_mio | input | 1 | 1 = memory, 0 = IO |
| req_lock | input | 1 | Transfer belongs to a locked sequence |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-clock pulse, read data valid |
| rsp_rdata | output | 32 | Merged read data |
| bus_addr | output | 30 | Address lines 31..2 |
| bus_be_n | output | 4 | Byte enables, active low |
| bus_wr | output | 1 | Cycle definition: write |
| bus_dc | output | 1 | Cycle definition: data/control |
| bus_mio | output | 1 | Cycle definition: memory/IO |
| ads_n | output | 1 | Address strobe, active low |
| lock_n | output | 1 | Bus lock, active low |
| bus_oe | output | 1 | Address and control outputs enabled |
| bus_d_out | output | 32 | Data driven onto the bus |
| bus_d_oe | output | 1 | Data lines driven |
| bus_d_in | input | 32 | Data read from the bus |
| rdy_n | input | 1 | Ready, active low |
| na_n | input | 1 | Next-address request, active low |
| bs16_n | input | 1 | Device is 16 bits wide, active low |
| hold | input | 1 | Another master requests the bus |
| hlda | output | 1 | Bus released to the other master |

## Verification
The hardest situation to reach from the ports is a pipelined request that is waiting while the current transfer turns into a split. The controller then has to strobe the second half at the old address and strobe the waiting request again before its data phase. To get there, the stimulus holds `na_n`, `bs16_n` and wait states at high rates in the same run. Hold and lock traffic are layered on top, so that release requests land at cycle boundaries both inside and outside locked sequences. A behavioural model in the bench tracks the queue of outstanding cycles and predicts every output on every clock.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  localparam int BCC_DW    = 32;
  localparam int BCC_LANES = BCC_DW / 8;
  localparam int BCC_HW    = BCC_DW / 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_HOLD = 2'd3
  } bcc_state_e;

  // A first-half cycle must be followed by a second one when the narrow
  // device answered and upper lanes take part.
  function automatic logic needs_split(input logic [BCC_LANES-1:0] be,
                                       input logic bs16_n,
                                       input logic upper_half);
    return !upper_half && !bs16_n && (|be[BCC_LANES-1:BCC_LANES/2]);
  endfunction

  function automatic logic [BCC_LANES-1:0] lanes_for_half(
      input logic [BCC_LANES-1:0] be, input logic upper_half);
    logic [BCC_LANES-1:0] r;
    r = be;
    if (upper_half) r[BCC_LANES/2-1:0] = '0;
    return r;
  endfunction

  function automatic logic [BCC_DW-1:0] wdata_for_half(
      input logic [BCC_DW-1:0] w, input logic upper_half);
    return upper_half ? {w[BCC_DW-1:BCC_HW], w[BCC_DW-1:BCC_HW]} : w;
  endfunction

  function automatic logic [BCC_DW-1:0] merge_read(
      input logic [BCC_DW-1:0] din, input logic [BCC_HW-1:0] low_saved,
      input logic upper_half, input logic bs16_n);
    if (upper_half)   return {din[BCC_HW-1:0], low_saved};
    else if (!bs16_n) return {{BCC_HW{1'b0}}, din[BCC_HW-1:0]};
    else              return din;
  endfunction

endpackage

// File: rtl/bcc_reqreg.sv
module bcc_reqreg #(
  parameter int W = 69
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bcc_fsm.sv
module bcc_fsm
  import bcc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_lock,
  input  logic                 hold,
  input  logic                 rdy_n,
  input  logic                 na_n,
  input  logic                 bs16_n,
  input  logic [BCC_LANES-1:0] cur_be,
  output bcc_state_e           state,
  output logic                 upper_half,
  output logic                 take,
  output logic                 take_cur,
  output logic                 take_nxt,
  output logic                 promote,
  output logic                 split_go,
  output logic                 final_done,
  output logic                 pipe_strobe,
  output logic                 nxt_valid,
  output logic                 lock_seq
);
  bcc_state_e nstate;
  logic hold_ok, ready_seen, stale;

  assign hold_ok    = hold && !lock_seq;
  assign ready_seen = (state == ST_DATA) && !rdy_n;
  assign split_go   = ready_seen && needs_split(cur_be, bs16_n, upper_half);
  assign final_done = ready_seen && !split_go;
  assign promote    = final_done && nxt_valid;
  assign take_cur   = req_valid && !hold_ok &&
                      ((state == ST_IDLE) || (final_done && !nxt_valid));
  assign take_nxt   = req_valid && !hold_ok && (state == ST_DATA) &&
                      rdy_n && !na_n && !nxt_valid;
  assign take       = take_cur || take_nxt;

  always_comb begin
    nstate = state;
    case (state)
      ST_IDLE: if (hold_ok) nstate = ST_HOLD;
               else if (req_valid) nstate = ST_ADDR;
      ST_ADDR: nstate = ST_DATA;
      ST_DATA: begin
        if (split_go) nstate = ST_ADDR;
        else if (final_done) begin
          if (nxt_valid)      nstate = stale ? ST_ADDR : ST_DATA;
          else if (hold_ok)   nstate = ST_HOLD;
          else if (req_valid) nstate = ST_ADDR;
          else                nstate = ST_IDLE;
        end
      end
      ST_HOLD: if (!hold) nstate = ST_IDLE;
      default: nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      upper_half  <= 1'b0;
      nxt_valid   <= 1'b0;
      pipe_strobe <= 1'b0;
      stale       <= 1'b0;
      lock_seq    <= 1'b0;
    end else begin
      state       <= nstate;
      pipe_strobe <= take_nxt;
      if (split_go)        upper_half <= 1'b1;
      else if (final_done) upper_half <= 1'b0;
      if (take_nxt)        nxt_valid <= 1'b1;
      else if (promote)    nxt_valid <= 1'b0;
      if (split_go && nxt_valid) stale <= 1'b1;
      else if (promote)          stale <= 1'b0;
      if (take) lock_seq <= req_lock;
    end
  end
endmodule

// File: rtl/bcc_rdmerge.sv
module bcc_rdmerge
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split_go,
  input  logic              final_done,
  input  logic              cur_wr,
  input  logic              upper_half,
  input  logic              bs16_n,
  input  logic [BCC_DW-1:0] din,
  output logic              rsp_valid,
  output logic [BCC_DW-1:0] rsp_rdata
);
  logic [BCC_HW-1:0] low_saved;
  logic              rd_end;

  assign rd_end = final_done && !cur_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_saved <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (split_go) low_saved <= din[BCC_HW-1:0];
      rsp_valid <= rd_end;
      if (rd_end) rsp_rdata <= merge_read(din, low_saved, upper_half, bs16_n);
    end
  end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int AW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_be,
  input  logic          req_wr,
  input  logic          req_dc,
  input  logic          req_mio,
  input  logic          req_lock,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [3:0]    bus_be_n,
  output logic          bus_wr,
  output logic          bus_dc,
  output logic          bus_mio,
  output logic          ads_n,
  output logic          lock_n,
  output logic          bus_oe,
  output logic [31:0]   bus_d_out,
  output logic          bus_d_oe,
  input  logic [31:0]   bus_d_in,
  input  logic          rdy_n,
  input  logic          na_n,
  input  logic          bs16_n,
  input  logic          hold,
  output logic          hlda
);
  localparam int REQ_W = AW + BCC_LANES + 3 + BCC_DW;

  bcc_state_e state;
  logic upper_half, take, take_cur, take_nxt, promote, split_go, final_done;
  logic pipe_strobe, nxt_valid, lock_seq;
  logic [REQ_W-1:0] req_pack, cur_q, nxt_q, cur_d;

  logic [AW-1:0]        cur_addr, nxt_addr;
  logic [BCC_LANES-1:0] cur_be, nxt_be;
  logic                 cur_wr, cur_dc, cur_mio, nxt_wr, nxt_dc, nxt_mio;
  logic [BCC_DW-1:0]    cur_wdata, nxt_wdata;
  logic                 active, show_nxt;

  assign req_pack = {req_addr, req_be, req_wr, req_dc, req_mio, req_wdata};
  assign cur_d    = promote ? nxt_q : req_pack;
  assign {cur_addr, cur_be, cur_wr, cur_dc, cur_mio, cur_wdata} = cur_q;
  assign {nxt_addr, nxt_be, nxt_wr, nxt_dc, nxt_mio, nxt_wdata} = nxt_q;

  bcc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lock(req_lock),
    .hold(hold), .rdy_n(rdy_n), .na_n(na_n), .bs16_n(bs16_n), .cur_be(cur_be),
    .state(state), .upper_half(upper_half), .take(take), .take_cur(take_cur),
    .take_nxt(take_nxt), .promote(promote), .split_go(split_go),
    .final_done(final_done), .pipe_strobe(pipe_strobe),
    .nxt_valid(nxt_valid), .lock_seq(lock_seq)
  );

  bcc_reqreg #(.W(REQ_W)) u_cur (
    .clk(clk), .rst_n(rst_n), .load(take_cur || promote), .d(cur_d), .q(cur_q)
  );

  bcc_reqreg #(.W(REQ_W)) u_nxt (
    .clk(clk), .rst_n(rst_n), .load(take_nxt), .d(req_pack), .q(nxt_q)
  );

  bcc_rdmerge u_rd (
    .clk(clk), .rst_n(rst_n), .split_go(split_go), .final_done(final_done),
    .cur_wr(cur_wr), .upper_half(upper_half), .bs16_n(bs16_n), .din(bus_d_in),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign req_ready = take;
  assign active    = (state == ST_ADDR) || (state == ST_DATA);
  assign show_nxt  = (state == ST_DATA) && nxt_valid;

  always_comb begin
    bus_addr = '0;
    bus_be_n = '1;
    bus_wr   = 1'b0;
    bus_dc   = 1'b0;
    bus_mio  = 1'b0;
    if (show_nxt) begin
      bus_addr = nxt_addr;
      bus_be_n = ~nxt_be;
      bus_wr   = nxt_wr;
      bus_dc   = nxt_dc;
      bus_mio  = nxt_mio;
    end else if (active) begin
      bus_addr = cur_addr;
      bus_be_n = ~lanes_for_half(cur_be, upper_half);
      bus_wr   = cur_wr;
      bus_dc   = cur_dc;
      bus_mio  = cur_mio;
    end
  end

  assign ads_n     = !((state == ST_ADDR) || pipe_strobe);
  assign bus_d_oe  = active && cur_wr;
  assign bus_d_out = bus_d_oe ? wdata_for_half(cur_wdata, upper_half) : '0;
  assign bus_oe    = (state != ST_HOLD);
  assign hlda      = (state == ST_HOLD);
  assign lock_n    = !lock_seq;
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker (
  input logic clk,
  input logic rst_n,
  input logic hold,
  input logic rdy_n,
  input logic hlda,
  input logic bus_oe,
  input logic ads_n,
  input logic lock_n,
  input logic bus_d_oe,
  input logic rsp_valid,
  input logic split_go,
  input logic final_done,
  input logic take_nxt
);
  p_float_in_hlda_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!bus_oe && ads_n && !bus_d_oe));

  p_grant_needs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(hold));

  p_keep_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && hold) |=> hlda);

  p_no_grant_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(lock_n));

  p_rsp_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(final_done));

  p_rsp_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!rdy_n));

  p_split_restrobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    split_go |=> !ads_n);

  p_early_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_nxt |=> !ads_n);
endmodule

bind bus_cycle_ctrl bcc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .rdy_n(rdy_n), .hlda(hlda),
  .bus_oe(bus_oe), .ads_n(ads_n), .lock_n(lock_n), .bus_d_oe(bus_d_oe),
  .rsp_valid(rsp_valid), .split_go(split_go), .final_done(final_done),
  .take_nxt(take_nxt)
);

// File: tb/bus_cycle_ctrl_test.sv
module bus_cycle_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int AW = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_be = 4'h1;
  logic req_wr = 1'b0, req_dc = 1'b0, req_mio = 1'b0, req_lock = 1'b0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic [3:0] bus_be_n;
  logic bus_wr, bus_dc, bus_mio, ads_n, lock_n, bus_oe, bus_d_oe, hlda;
  logic [31:0] bus_d_out;
  logic [31:0] bus_d_in = '0;
  logic rdy_n = 1'b1, na_n = 1'b1, bs16_n = 1'b1, hold = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  bus_cycle_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_be(req_be), .req_wr(req_wr), .req_dc(req_dc),
    .req_mio(req_mio), .req_lock(req_lock), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_be_n(bus_be_n), .bus_wr(bus_wr), .bus_dc(bus_dc), .bus_mio(bus_mio),
    .ads_n(ads_n), .lock_n(lock_n), .bus_oe(bus_oe), .bus_d_out(bus_d_out),
    .bus_d_oe(bus_d_oe), .bus_d_in(bus_d_in), .rdy_n(rdy_n), .na_n(na_n),
    .bs16_n(bs16_n), .hold(hold), .hlda(hlda)
  );

  int checks = 0, failures = 0;
  bit done_flag = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  typedef struct {
    logic [AW-1:0] a; logic [3:0] be; logic wr, dc, mio; logic [31:0] wd;
  } xfer_t;

  xfer_t oq[$];            // outstanding transfers, front = in data phase
  int    mph = 0;          // 0 idle, 1 strobe, 2 waiting for ready, 3 released
  bit    m_hi = 0, m_early = 0, m_stale = 0, m_lk = 0, m_rv = 0;
  logic [15:0] m_lo = '0;
  logic [31:0] m_rd = '0;
  bit    took = 0;

  function automatic xfer_t grab();
    xfer_t t;
    t.a = req_addr; t.be = req_be; t.wr = req_wr; t.dc = req_dc;
    t.mio = req_mio; t.wd = req_wdata;
    return t;
  endfunction

  always @(posedge clk) begin
    bit acc, early, give;
    acc = 0; early = 0;
    give = hold && !m_lk;
    if (!rst_n) begin
      oq.delete(); mph = 0; m_hi = 0; m_early = 0; m_stale = 0; m_lk = 0;
      m_rv = 0; m_lo = '0; took = 0;
    end else begin
      m_rv = 0;
      case (mph)
        0: if (give) mph = 3;
           else if (req_valid) begin acc = 1; oq.push_back(grab()); mph = 1; end
        1: mph = 2;
        2: if (!rdy_n) begin
             if (!m_hi && !bs16_n && (oq[0].be[3] || oq[0].be[2])) begin
               m_hi = 1; m_lo = bus_d_in[15:0]; mph = 1;
               if (oq.size() > 1) m_stale = 1;
             end else begin
               if (!oq[0].wr) begin
                 m_rv = 1;
                 if (m_hi) m_rd = {bus_d_in[15:0], m_lo};
                 else if (!bs16_n) m_rd = {16'h0000, bus_d_in[15:0]};
                 else m_rd = bus_d_in;
               end
               void'(oq.pop_front());
               m_hi = 0;
               if (oq.size() > 0) begin mph = m_stale ? 1 : 2; m_stale = 0; end
               else if (give) mph = 3;
               else if (req_valid) begin acc = 1; oq.push_back(grab()); mph = 1; end
               else mph = 0;
             end
           end else if (!na_n && req_valid && oq.size() == 1 && !give) begin
             acc = 1; oq.push_back(grab()); early = 1;
           end
        default: if (!hold) mph = 0;
      endcase
      // R9: acceptance must match the model at this very edge
      chk("R9", "req_ready", {31'b0, req_ready}, {31'b0, acc});
      if (acc) m_lk = req_lock;
      m_early = early;
      took = acc;
    end
  end

  task automatic compare_all();
    logic [AW-1:0] ea; logic [3:0] ebe; logic ew, edc, emio;
    ea = '0; ebe = 4'hF; ew = 0; edc = 0; emio = 0;
    if (mph == 2 && oq.size() > 1) begin
      ea = oq[1].a; ebe = ~oq[1].be; ew = oq[1].wr; edc = oq[1].dc; emio = oq[1].mio;
    end else if (mph == 1 || mph == 2) begin
      ea = oq[0].a; ebe = ~(m_hi ? (oq[0].be & 4'b1100) : oq[0].be);
      ew = oq[0].wr; edc = oq[0].dc; emio = oq[0].mio;
    end
    chk("R2", "ads_n", {31'b0, ads_n}, {31'b0, !(mph == 1 || m_early)});
    chk("R8", "bus_addr", {2'b0, bus_addr}, {2'b0, ea});
    chk("R2", "cycle_def", {29'b0, bus_wr, bus_dc, bus_mio}, {29'b0, ew, edc, emio});
    chk("R4 R5", "bus_be_n", {28'b0, bus_be_n}, {28'b0, ebe});
    chk("R10", "hlda", {31'b0, hlda}, {31'b0, mph == 3});
    chk("R10", "bus_oe", {31'b0, bus_oe}, {31'b0, mph != 3});
    chk("R11", "lock_n", {31'b0, lock_n}, {31'b0, !m_lk});
    chk("R5", "d_oe", {31'b0, bus_d_oe},
        {31'b0, (mph == 1 || mph == 2) && oq[0].wr});
    if (bus_d_oe && (mph == 1 || mph == 2))
      chk("R5", "d_out", bus_d_out,
          m_hi ? {oq[0].wd[31:16], oq[0].wd[31:16]} : oq[0].wd);
    chk("R3 R7", "rsp_valid", {31'b0, rsp_valid}, {31'b0, m_rv});
    if (rsp_valid && m_rv) chk("R6 R7", "rsp_rdata", rsp_rdata, m_rd);
  endtask

  // ---------------- stimulus ----------------
  int p_wait, p_na, p_bs16, p_hold, p_lock, p_req;

  task automatic drive();
    rdy_n  = ($urandom_range(99) < p_wait);
    na_n   = !($urandom_range(99) < p_na);
    bs16_n = !($urandom_range(99) < p_bs16);
    if ($urandom_range(99) < p_hold) hold = !hold;
    bus_d_in = $urandom;
    if (!req_valid || took) begin
      took = 0;
      if ($urandom_range(99) < p_req) begin
        req_valid = 1;
        req_addr  = AW'($urandom);
        req_be    = 4'($urandom_range(15, 1));
        req_wr    = $urandom_range(1);
        req_dc    = $urandom_range(1);
        req_mio   = $urandom_range(1);
        req_lock  = ($urandom_range(99) < p_lock);
        req_wdata = $urandom;
      end else req_valid = 0;
    end
  endtask

  task automatic run_phase(input int w, input int n, input int b, input int h,
                           input int l, input int r, input int cycles);
    p_wait = w; p_na = n; p_bs16 = b; p_hold = h; p_lock = l; p_req = r;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_all();
      drive();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, before any edge with reset released
    chk("R1", "ads_n", {31'b0, ads_n}, 32'd1);
    chk("R1", "lock_n", {31'b0, lock_n}, 32'd1);
    chk("R1", "hlda", {31'b0, hlda}, 32'd0);
    chk("R1", "d_oe", {31'b0, bus_d_oe}, 32'd0);
    chk("R1", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1", "bus_oe", {31'b0, bus_oe}, 32'd1);
    run_phase(0,  0,  0,  0,  0, 100, 1500);  // back-to-back, R9
    run_phase(60, 0,  0,  0,  0,  50, 1500);  // wait states, R3
    run_phase(30, 0,  70, 0,  0,  80, 1500);  // narrow device, R5 R6
    run_phase(60, 60, 0,  0,  0,  90, 1500);  // pipelining, R8
    run_phase(50, 50, 50, 0,  0,  90, 2000);  // pipelining with splits
    run_phase(30, 20, 20, 10, 0,  70, 1500);  // release, R10
    run_phase(40, 30, 30, 10, 50, 80, 2000);  // locked sequences, R11
    hold = 0;
    run_phase(0,  0,  0,  0,  0,   0, 20);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule